// File: doc/BRIEF.md
# Subtract-Multiplex Array Square Root

This block computes the integer square root of an unsigned radicand in a single combinational path, with no clock. It is an array of rows. Each row finds one root bit, working from the most significant bit down. The radicand is cut into two-bit pairs counted from the binary point, and the row for the highest pair goes first.

Each row joins the remainder it receives with the next radicand pair. From that value it subtracts the root found so far with the bits 01 appended below it. The row's final borrow decides two things. It selects between the difference and the unchanged remainder for the next row, and its inverse is the root bit. No row ever adds back a correction term. The last row's remainder is also brought out, so a consumer can rebuild the radicand as root² + remainder.

The radicand width is a parameter that must be even. The default is 8 bits, which gives a 4-bit root and a 5-bit remainder. 16 bits gives an 8-bit root.

Top module: `sqrt_sm_array`

## Requirements
- R1: For every radicand, root_o is the floor of its square root: root_o² ≤ rad_i < (root_o+1)².
- R2: rem_o equals rad_i − root_o².
- R3: rem_o never exceeds 2·root_o, and the top bit of every row's difference-or-keep result is zero.
- R4: When a row's trial subtraction does not borrow, that row's root bit is 1 and the difference passes on. Example: rad_i = 0x40 gives root 8, remainder 0.
- R5: When a row's trial subtraction borrows, that row's root bit is 0 and the incoming remainder passes on unchanged. Example: rad_i = 0x3F, whose top pair 00 makes the first row borrow, gives root 7, remainder 14.
- R6: The radicand 93 (pairs 01 01 11 01) gives root bits 1,0,0,1, so root_o = 9 and rem_o = 12.
- R7: The extremes of the default width: 0 gives root 0, remainder 0, and 255 gives root 15, remainder 30.
- R8: Every perfect square k² gives root k and remainder 0.
- R9: With RAD_W = 16 the same array gives an 8-bit root. For example, 65535 gives root 255, remainder 510, and R1 to R3 hold across that width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rad_i | input | RAD_W | Unsigned radicand |
| root_o | output | RAD_W/2 | Floor of the square root |
| rem_o | output | RAD_W/2+1 | rad_i minus root_o squared |

## Verification
The in-line checks assume that rad_i carries no unknown bits whenever it is sampled. They also assume that RAD_W is even, so that every row takes a whole pair. The bench keeps to this in two ways. It drives rad_i from a defined value before the first check, and it changes rad_i only half a cycle before outputs are read, so the combinational array has settled when sampled. The 8-bit instance is swept over its full input range. The 16-bit instance is fed perfect squares, their neighbours and a stepped sweep, which stay within its legal range.

// File: rtl/sqrt_sm_pkg.sv
package sqrt_sm_pkg;
    // Width of the minuend in row k: carried remainder (k+1 bits) plus one pair.
    function automatic int row_width(input int k);
        return k + 3;
    endfunction
endpackage

// File: rtl/sqrt_sm_cell.sv
module sqrt_sm_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic bin_i,
    input  logic keep_i,
    output logic bout_o,
    output logic res_o
);
    logic diff_w;

    always_comb begin
        diff_w = a_i ^ b_i ^ bin_i;
        bout_o = (~a_i & b_i) | (~a_i & bin_i) | (b_i & bin_i);
        res_o  = keep_i ? a_i : diff_w;
    end
endmodule

// File: rtl/sqrt_sm_row.sv
module sqrt_sm_row #(
    parameter int W = 3
) (
    input  logic [W-1:0] min_i,
    input  logic [W-1:0] sub_i,
    output logic [W-1:0] res_o,
    output logic         bit_o
);
    logic [W:0] brw_w;
    logic       keep_w;

    assign brw_w[0] = 1'b0;
    assign keep_w   = brw_w[W];
    assign bit_o    = ~keep_w;

    for (genvar j = 0; j < W; j++) begin : cell_g
        sqrt_sm_cell cell_i (
            .a_i    (min_i[j]),
            .b_i    (sub_i[j]),
            .bin_i  (brw_w[j]),
            .keep_i (keep_w),
            .bout_o (brw_w[j+1]),
            .res_o  (res_o[j])
        );
    end

    always_comb begin
        if (!$isunknown({min_i, sub_i})) begin
            if (bit_o)
                p_take_diff_r4: assert (res_o == W'(min_i - sub_i) && min_i >= sub_i)
                    else $error("row took difference but result wrong");
            else
                p_keep_rem_r5: assert (res_o == min_i && min_i < sub_i)
                    else $error("row kept remainder but result wrong");
        end
    end
endmodule

// File: rtl/sqrt_sm_array.sv
module sqrt_sm_array #(
    parameter int RAD_W = 8
) (
    input  logic [RAD_W-1:0]   rad_i,
    output logic [RAD_W/2-1:0] root_o,
    output logic [RAD_W/2:0]   rem_o
);
    import sqrt_sm_pkg::*;

    localparam int ROOT_W = RAD_W / 2;
    localparam int REM_W  = ROOT_W + 1;
    localparam int CHK_W  = RAD_W + 2;

    logic [ROOT_W-1:0] root_w;

    for (genvar k = 0; k < ROOT_W; k++) begin : row_g
        localparam int MW = row_width(k);
        logic [MW-1:0] min_w;
        logic [MW-1:0] sub_w;
        logic [MW-1:0] res_w;
        logic [k+1:0]  rem_w;
        logic          bit_w;

        if (k == 0) begin : first_g
            assign min_w = {1'b0, rad_i[RAD_W-1 -: 2]};
            assign sub_w = MW'(3'b001);
        end else begin : next_g
            assign min_w = {row_g[k-1].rem_w, rad_i[RAD_W-1-2*k -: 2]};
            assign sub_w = {1'b0, root_w[ROOT_W-1 -: k], 2'b01};
        end

        sqrt_sm_row #(.W(MW)) row_i (
            .min_i (min_w),
            .sub_i (sub_w),
            .res_o (res_w),
            .bit_o (bit_w)
        );

        assign root_w[ROOT_W-1-k] = bit_w;
        assign rem_w              = res_w[MW-2:0];

        always_comb begin
            if (!$isunknown(rad_i))
                p_row_fits_r3: assert (res_w[MW-1] == 1'b0)
                    else $error("row remainder overflowed its width");
        end
    end

    assign root_o = root_w;
    assign rem_o  = row_g[ROOT_W-1].rem_w;

    logic [CHK_W-1:0] sq_w;
    logic [CHK_W-1:0] nx_w;

    always_comb begin
        sq_w = CHK_W'(root_o) * CHK_W'(root_o);
        nx_w = (CHK_W'(root_o) + 1) * (CHK_W'(root_o) + 1);
        if (!$isunknown(rad_i)) begin
            p_floor_r1: assert (sq_w <= CHK_W'(rad_i) && nx_w > CHK_W'(rad_i))
                else $error("root is not the floor square root");
            p_rebuild_r2: assert (sq_w + CHK_W'(rem_o) == CHK_W'(rad_i))
                else $error("root squared plus remainder differs from radicand");
            p_rem_bound_r3: assert (REM_W'(rem_o) <= {root_o, 1'b0})
                else $error("remainder exceeds twice the root");
        end
    end
endmodule

// File: tb/sqrt_sm_array_tb_top.sv
module sqrt_sm_array_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0]  rad8;
    logic [3:0]  root8;
    logic [4:0]  rem8;
    logic [15:0] rad16;
    logic [7:0]  root16;
    logic [8:0]  rem16;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    sqrt_sm_array #(.RAD_W(8)) dut_i (
        .rad_i (rad8), .root_o (root8), .rem_o (rem8));
    sqrt_sm_array #(.RAD_W(16)) dut16_i (
        .rad_i (rad16), .root_o (root16), .rem_o (rem16));

    function automatic int ref_root(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply8(input int v);
        @(posedge clk);
        rad8 = 8'(v);
        @(negedge clk);
    endtask

    task automatic apply16(input int v);
        @(posedge clk);
        rad16 = 16'(v);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        cmp("R7 root after reset", int'(root8), 0);
        cmp("R7 rem after reset", int'(rem8), 0);
    endtask

    task automatic t_extremes();
        apply8(0);
        cmp("R7 root(0)", int'(root8), 0);
        cmp("R7 rem(0)", int'(rem8), 0);
        apply8(255);
        cmp("R7 root(255)", int'(root8), 15);
        cmp("R7 rem(255)", int'(rem8), 30);
    endtask

    task automatic t_worked_example();
        apply8(93);
        cmp("R6 root(93)", int'(root8), 9);
        cmp("R6 rem(93)", int'(rem8), 12);
    endtask

    task automatic t_row_decisions();
        apply8(8'h40);
        cmp("R4 root(0x40)", int'(root8), 8);
        cmp("R4 rem(0x40)", int'(rem8), 0);
        apply8(8'h3F);
        cmp("R5 root(0x3F)", int'(root8), 7);
        cmp("R5 rem(0x3F)", int'(rem8), 14);
        apply8(8'h03);
        cmp("R5 root(0x03)", int'(root8), 1);
        cmp("R5 rem(0x03)", int'(rem8), 2);
    endtask

    task automatic t_sweep8();
        for (int v = 0; v < 256; v++) begin
            int r;
            apply8(v);
            r = ref_root(v);
            cmp("R1 root sweep", int'(root8), r);
            cmp("R2 rem sweep", int'(rem8), v - r * r);
            cmp("R3 rem bound", int'(rem8 <= {root8, 1'b0}), 1);
        end
    endtask

    task automatic t_squares8();
        for (int k = 0; k < 16; k++) begin
            apply8(k * k);
            cmp("R8 root square", int'(root8), k);
            cmp("R8 rem square", int'(rem8), 0);
        end
    endtask

    task automatic t_wide16();
        apply16(65535);
        cmp("R9 root(65535)", int'(root16), 255);
        cmp("R9 rem(65535)", int'(rem16), 510);
        for (int k = 1; k < 256; k += 7) begin
            int r;
            for (int d = -1; d <= 1; d++) begin
                int v = k * k + d;
                apply16(v);
                r = ref_root(v);
                cmp("R9 root wide", int'(root16), r);
                cmp("R9 rem wide", int'(rem16), v - r * r);
            end
        end
        for (int v = 0; v < 65536; v += 397) begin
            int r;
            apply16(v);
            r = ref_root(v);
            cmp("R9 root step", int'(root16), r);
            cmp("R9 rem step", int'(rem16), v - r * r);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        rad8  = '0;
        rad16 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_extremes();
        t_worked_example();
        t_row_decisions();
        t_squares8();
        t_sweep8();
        t_wide16();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule